// File: doc/BRIEF.md
# Indirect Video Memory Access Port

This block lets a processor reach video memory without mapping it into its own address space. The processor sees three word registers: a pointer, a data window and a signed step. Loading the pointer selects a location in video memory. Writing the data window stores a word there and then moves the pointer by the step. Reading the pointer or the data window returns the word at the pointer and leaves the pointer where it was. A step of +1 walks memory in order. A step of +32 walks down a column of a 32-wide map. A negative step walks backwards.

Video memory is a synchronous single-port RAM shared with the display engine. The port therefore asks for each access with a request and waits for a grant. A data write is held in a one-word slot until it is granted, so the processor can go on at once. The port also keeps a copy of the word at the current pointer, and it refreshes that copy after every pointer change. While a write is still waiting, or the copy is not yet fresh, the port holds its ready output low for any access that depends on them.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer is 0x0000 and the step is 0x0001. A read of the step register returns 0x0001, and the first data write lands at address 0x0000.
- R2: A write with register code 0 loads the pointer with the written value.
- R3: A read with register code 0 or code 1 returns the video memory word at the pointer, and it never changes the pointer.
- R4: A write with register code 1 stores the written word at the pointer. The pointer then becomes pointer + step, wrapping modulo 2^16.
- R5: Register code 2 holds the step. It can be written and read back, and it is used as a two's complement value, so 0xFFFF steps backwards by one and 0x0000 keeps the pointer in place.
- R6: A data write is presented on the memory side with vm_req=1 and vm_we=1. vm_addr and vm_wdata stay stable until a cycle with vm_gnt=1.
- R7: A data write issued while an earlier data write is still waiting for its grant sees cpu_ready=0 until the earlier one is granted. The write is taken only when cpu_ready=1.
- R8: A read of code 0 or 1 always returns the word at the current pointer. This includes words written by this port just before the read. The read waits, with cpu_ready low, until the copy has been refreshed from memory. Read data arrives on vm_rdata one cycle after a granted read.
- R9: Register code 3 is unused. Writes to it change neither the pointer nor the step, and reads of it return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Register code: 0 pointer, 1 data, 2 step, 3 unused |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access is taken at the clock edge where cpu_sel and cpu_ready are both high |
| vm_req | output | 1 | Memory access request |
| vm_we | output | 1 | Memory write enable |
| vm_addr | output | ADDR_W | Memory address |
| vm_wdata | output | DATA_W | Memory write data |
| vm_gnt | input | 1 | Grant; the request completes in a cycle where it is high |
| vm_rdata | input | DATA_W | Memory read data, one cycle after a granted read |

## Verification
Two cases are hard to reach from the ports. In the first, a second data write arrives while the first is still waiting for its grant. In the second, the pointer moves while a refresh read is still in flight, so the returned word belongs to an address that is no longer current. The bench reaches the first case by forcing the grant low across two back-to-back data writes, and it checks the stall and the frozen memory request cycle by cycle. It reaches the second with long random sequences under a random grant. These sequences mix pointer loads, small positive, negative and zero steps, writes and reads in a small window and across the 0xFFFF wrap. Every read is checked against a reference model.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STEP = 2'd2,
        SEL_NONE = 2'd3
    } vp_sel_e;

endpackage

// File: rtl/vram_port_regs.sv
module vram_port_regs
    import vram_port_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int STEP_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  vp_sel_e           wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] step,
    output logic              ptr_moved,
    output logic              data_push
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] step;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ptr_moved = 1'b0;
        data_push = 1'b0;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_PTR: begin
                    st_d.ptr  = ADDR_W'(wr_val);
                    ptr_moved = 1'b1;
                end
                SEL_DATA: begin
                    st_d.ptr  = st_q.ptr + st_q.step;
                    ptr_moved = 1'b1;
                    data_push = 1'b1;
                end
                SEL_STEP: st_d.step = ADDR_W'(wr_val);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.step <= ADDR_W'(STEP_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign step = st_q.step;

endmodule

// File: rtl/vram_port_xfer.sv
module vram_port_xfer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              ptr_moved,
    input  logic [ADDR_W-1:0] ptr,
    output logic              wr_busy,
    output logic              rd_fresh,
    output logic [DATA_W-1:0] rd_word,
    output logic              vm_req,
    output logic              vm_we,
    output logic [ADDR_W-1:0] vm_addr,
    output logic [DATA_W-1:0] vm_wdata,
    input  logic              vm_gnt,
    input  logic [DATA_W-1:0] vm_rdata
);

    typedef struct packed {
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              fetch_need;
        logic              fetch_wait;
        logic [DATA_W-1:0] word;
    } xfer_t;

    xfer_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        vm_req   = 1'b0;
        vm_we    = 1'b0;
        vm_addr  = ptr;
        vm_wdata = st_q.wr_data;

        // a queued write always goes first so a refresh sees its data
        if (st_q.wr_pend) begin
            vm_req  = 1'b1;
            vm_we   = 1'b1;
            vm_addr = st_q.wr_addr;
        end else if (st_q.fetch_need && !st_q.fetch_wait) begin
            vm_req = 1'b1;
        end

        if (st_q.fetch_wait) begin
            st_d.word       = vm_rdata;
            st_d.fetch_wait = 1'b0;
        end

        if (vm_req && vm_gnt) begin
            if (vm_we) begin
                st_d.wr_pend = 1'b0;
            end else begin
                st_d.fetch_need = 1'b0;
                st_d.fetch_wait = 1'b1;
            end
        end

        if (push) begin
            st_d.wr_pend = 1'b1;
            st_d.wr_addr = push_addr;
            st_d.wr_data = push_data;
        end

        // a move during an in-flight refresh forces another one
        if (ptr_moved) begin
            st_d.fetch_need = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.fetch_need <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_busy  = st_q.wr_pend;
    assign rd_fresh = !st_q.wr_pend && !st_q.fetch_need && !st_q.fetch_wait;
    assign rd_word  = st_q.word;

endmodule

// File: rtl/vram_port.sv
module vram_port
    import vram_port_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int STEP_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_reg,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              vm_req,
    output logic              vm_we,
    output logic [ADDR_W-1:0] vm_addr,
    output logic [DATA_W-1:0] vm_wdata,
    input  logic              vm_gnt,
    input  logic [DATA_W-1:0] vm_rdata
);

    vp_sel_e           sel;
    logic              mem_rd;
    logic              data_wr;
    logic              stall;
    logic              acc_wr;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] step_q;
    logic              ptr_moved;
    logic              data_push;
    logic              wr_busy;
    logic              rd_fresh;
    logic [DATA_W-1:0] rd_word;

    assign sel     = vp_sel_e'(cpu_reg);
    assign mem_rd  = !cpu_we && (sel == SEL_PTR || sel == SEL_DATA);
    assign data_wr = cpu_we && (sel == SEL_DATA);
    assign stall   = cpu_sel && ((data_wr && wr_busy) || (mem_rd && !rd_fresh));

    assign cpu_ready = !stall;
    assign acc_wr    = cpu_sel && cpu_we && !stall;

    always_comb begin
        unique case (sel)
            SEL_PTR, SEL_DATA: cpu_rdata = rd_word;
            SEL_STEP:          cpu_rdata = DATA_W'($signed(step_q));
            default:           cpu_rdata = '0;
        endcase
    end

    vram_port_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .STEP_RST(STEP_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr),
        .wr_sel   (sel),
        .wr_val   (cpu_wdata),
        .ptr      (ptr_q),
        .step     (step_q),
        .ptr_moved(ptr_moved),
        .data_push(data_push)
    );

    vram_port_xfer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (data_push),
        .push_addr(ptr_q),
        .push_data(cpu_wdata),
        .ptr_moved(ptr_moved),
        .ptr      (ptr_q),
        .wr_busy  (wr_busy),
        .rd_fresh (rd_fresh),
        .rd_word  (rd_word),
        .vm_req   (vm_req),
        .vm_we    (vm_we),
        .vm_addr  (vm_addr),
        .vm_wdata (vm_wdata),
        .vm_gnt   (vm_gnt),
        .vm_rdata (vm_rdata)
    );

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [1:0]        cpu_reg,
    input logic              cpu_ready,
    input logic              vm_req,
    input logic              vm_we,
    input logic              vm_gnt,
    input logic [ADDR_W-1:0] vm_addr,
    input logic [DATA_W-1:0] vm_wdata,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W-1:0] step
);

    p_rd_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_we && cpu_reg[1] == 1'b0 && cpu_ready |=> $stable(ptr));

    p_step_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && cpu_we && cpu_reg == 2'd1 && cpu_ready
        |=> ptr == ADDR_W'($past(ptr) + $past(step)));

    p_write_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vm_req && vm_we && !vm_gnt
        |=> vm_req && vm_we && $stable(vm_addr) && $stable(vm_wdata));

    p_second_write_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && cpu_we && cpu_reg == 2'd1 && vm_req && vm_we && !vm_gnt |-> !cpu_ready);

    p_read_not_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_we && cpu_reg[1] == 1'b0 && cpu_ready |-> !vm_req);

    p_unused_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && cpu_we && cpu_reg == 2'd3 |=> $stable(ptr) && $stable(step));

endmodule

bind vram_port vram_port_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_sel  (cpu_sel),
    .cpu_we   (cpu_we),
    .cpu_reg  (cpu_reg),
    .cpu_ready(cpu_ready),
    .vm_req   (vm_req),
    .vm_we    (vm_we),
    .vm_gnt   (vm_gnt),
    .vm_addr  (vm_addr),
    .vm_wdata (vm_wdata),
    .ptr      (ptr_q),
    .step     (step_q)
);

// File: tb/vram_port_bench.sv
`timescale 1ns/1ps
module vram_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_reg = 2'd0;
    logic [15:0] cpu_wdata = 16'h0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        vm_req;
    logic        vm_we;
    logic [15:0] vm_addr;
    logic [15:0] vm_wdata;
    logic        vm_gnt = 1'b0;
    logic [15:0] vm_rdata = 16'h0;

    int n_chk = 0;
    int n_bad = 0;
    bit gnt_hold = 1'b0;
    int gnt_pct = 60;

    logic [15:0] vmem    [int unsigned];
    logic [15:0] ref_mem [int unsigned];
    logic [15:0] ref_ptr;
    logic [15:0] ref_step;

    always #2 clk = ~clk;

    vram_port u_vram_port (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_reg(cpu_reg),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .vm_req(vm_req), .vm_we(vm_we), .vm_addr(vm_addr), .vm_wdata(vm_wdata),
        .vm_gnt(vm_gnt), .vm_rdata(vm_rdata)
    );

    function automatic logic [15:0] fill(input logic [15:0] a);
        return a ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        if (vmem.exists(int'(a))) return vmem[int'(a)];
        return fill(a);
    endfunction

    function automatic logic [15:0] ref_rd(input logic [15:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return fill(a);
    endfunction

    // memory model: synchronous single port, data one cycle after grant
    always @(posedge clk) begin
        if (vm_req && vm_gnt) begin
            if (vm_we) vmem[int'(vm_addr)] = vm_wdata;
            else       vm_rdata <= mem_rd(vm_addr);
        end
    end

    always @(negedge clk) begin
        vm_gnt <= gnt_hold ? 1'b0 : (($urandom % 100) < gnt_pct);
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] r, input logic [15:0] d,
                       output logic [15:0] q);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = we; cpu_reg = r; cpu_wdata = d;
        q = 16'h0;
        while (1) begin
            #1;
            if (cpu_ready) begin
                q = cpu_rdata;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #0.5 cpu_sel = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        logic [15:0] q;
        acc(1'b1, 2'd0, a, q);
        ref_ptr = a;
    endtask

    task automatic set_step(input logic [15:0] s);
        logic [15:0] q;
        acc(1'b1, 2'd2, s, q);
        ref_step = s;
    endtask

    task automatic put(input logic [15:0] d);
        logic [15:0] q;
        acc(1'b1, 2'd1, d, q);
        ref_mem[int'(ref_ptr)] = d;
        ref_ptr = ref_ptr + ref_step;
    endtask

    task automatic get(input logic [1:0] r, input string req);
        logic [15:0] q;
        acc(1'b0, r, 16'h0, q);
        if (r == 2'd2)      chk(req, q, ref_step);
        else if (r == 2'd3) chk(req, q, 16'h0000);
        else                chk(req, q, ref_rd(ref_ptr));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] q;
        void'($urandom(32'd4242));
        ref_ptr = 16'h0; ref_step = 16'h1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        get(2'd2, "R1 step reset");
        get(2'd1, "R1 pointer reset read");
        put(16'h1111);
        get(2'd0, "R1 R3 read after first write");

        // R2 R4: load pointer, forward walk with step 3
        set_ptr(16'h0010);
        set_step(16'h0003);
        get(2'd2, "R5 step readback");
        put(16'hA001); put(16'hA002); put(16'hA003);
        set_ptr(16'h0013);
        get(2'd1, "R2 R4 word at 0x0013");
        set_ptr(16'h0016);
        get(2'd0, "R2 R4 word at 0x0016");

        // R3: repeated reads keep the pointer
        set_ptr(16'h0040);
        get(2'd1, "R3 read 1");
        get(2'd0, "R3 read 2");
        get(2'd1, "R3 read 3");
        put(16'hBEEF);
        set_ptr(16'h0040);
        get(2'd1, "R3 write landed at unmoved pointer");

        // R5 R4: negative step across the wrap
        set_ptr(16'h0001);
        set_step(16'hFFFF);
        get(2'd2, "R5 negative step readback");
        put(16'hC001); put(16'hC000); put(16'hCFFF);
        set_ptr(16'hFFFF);
        get(2'd1, "R4 wrap below zero");
        set_ptr(16'h0000);
        get(2'd1, "R4 negative step second word");

        // R5 R8: zero step, read right after write sees the new word
        set_step(16'h0000);
        set_ptr(16'h0200);
        put(16'h7777);
        get(2'd1, "R8 read after write step 0");
        put(16'h8888);
        get(2'd0, "R8 overwrite step 0");

        // R9: unused code
        set_step(16'h0002);
        set_ptr(16'h0300);
        acc(1'b1, 2'd3, 16'hDEAD, q);
        get(2'd3, "R9 unused read zero");
        get(2'd2, "R9 step untouched");
        put(16'h3030);
        set_ptr(16'h0300);
        get(2'd1, "R9 pointer untouched");

        // R6 R7: hold grant off across two data writes
        set_step(16'h0001);
        set_ptr(16'h0500);
        @(negedge clk); gnt_hold = 1'b1;
        repeat (2) @(negedge clk);
        put(16'hAAAA);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_reg = 2'd1; cpu_wdata = 16'hBBBB;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R7 second write stalled", {15'h0, cpu_ready}, 16'h0000);
            chk("R6 request held", {14'h0, vm_req, vm_we}, 16'h0003);
            chk("R6 address held", vm_addr, 16'h0500);
            chk("R6 data held", vm_wdata, 16'hAAAA);
            @(negedge clk);
        end
        gnt_hold = 1'b0;
        while (1) begin
            #1;
            if (cpu_ready) begin @(posedge clk); break; end
            @(negedge clk);
        end
        #0.5 cpu_sel = 1'b0;
        ref_mem[int'(ref_ptr)] = 16'hBBBB;
        ref_ptr = ref_ptr + ref_step;
        set_ptr(16'h0500);
        get(2'd1, "R6 R7 first held write");
        set_ptr(16'h0501);
        get(2'd1, "R7 second write after stall");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom % 8;
            gnt_pct = 20 + ($urandom % 80);
            case (op)
                0: set_ptr((($urandom % 2) != 0 ? 16'hFFF0 : 16'h0000) + 16'($urandom % 32));
                1: set_step(16'($signed(($urandom % 9)) - 4));
                2, 3, 4: put(16'($urandom));
                5: get(2'd1, "R3 R8 random data read");
                6: get(2'd0, "R3 R8 random pointer read");
                default: get(2'd2, "R5 random step read");
            endcase
        end
        gnt_pct = 60;
        get(2'd1, "R8 drain");
        foreach (ref_mem[k]) chk("R4 final memory", mem_rd(16'(k)), ref_mem[k]);
        finish_run();
    end

endmodule